// File: doc/BRIEF.md
# Window Watchdog Timer with Early Warning

This block guards a system against software that has stopped running properly. A 7-bit down-counter decrements at a slow rate taken from the bus clock. The rate comes from a fixed power-of-two divider, which is 4096 by default, followed by a software-selected prescaler of 1 to 128. When counter bit 6 clears, the block issues a one-cycle reset request. Software has to reload the counter in time, but not too early. A reload while the counter is still above a programmed window value is also treated as a fault and requests a reset.

One counter step before expiry, on the step into value 0x40, a sticky warning flag is set. If the warning is enabled, it drives an interrupt. The handler can then reload the counter and carry on without a reset. Once the watchdog is switched on, software cannot switch it off. A configuration bit decides whether a debug-halt input freezes the counter.

The registers sit on a simple word-indexed register bus with byte-lane strobes, so 16-bit and 32-bit writes both work.

Top module: `window_watchdog`

## Requirements
- R1: The counter advances once every 2^(DIV_LOG2+P) bus cycles, where P is the 3-bit prescaler. The prescale counter runs freely from reset. A counter value with low six bits T reaches expiry after T+1 advances. With DIV_LOG2=12, P=3 and T=63, this is 2,097,152 cycles, or 43.69 ms at 48 MHz.
- R2: After reset, the control register reads 0x7F, the configuration register reads 0x7F, the status register reads 0, and irq and rst_req are low.
- R3: On each advance the counter decrements by one and wraps from 0 to 0x7F, whether or not the watchdog is active. It holds while dbg_halt is high and the freeze bit is set. A counter write in the same cycle takes priority over an advance.
- R4: An advance from 0x41 to 0x40 sets the status flag. irq equals the flag ANDed with the warning-enable bit.
- R5: Writing status bit 0 as 0, with strobe lane 0 set, clears the flag. Writing 1 leaves it unchanged. A set in the same cycle wins over a clear.
- R6: If the watchdog is active, an advance from 0x40 to 0x3F produces a rst_req pulse exactly one cycle long, in the cycle after that advance. An inactive watchdog never requests a reset on expiry.
- R7: A control write with bit 6 equal to 0 requests a reset in the next cycle if the watchdog is active after that write. This includes the write that activates it.
- R8: A control write made while the current counter value is above the 7-bit window value requests a reset in the next cycle if the watchdog is active after that write. A write with the counter at or below the window does not.
- R9: Writing control bit 7 as 1 activates the watchdog. Only the block reset deactivates it, and bit 7 reads back as the activation state.
- R10: Register map, indexed by the word address:
  - Index 0 is control: bits [6:0] hold the counter and bit 7 is activation. Only writes with lane 0 take effect.
  - Index 1 is configuration: bits [6:0] hold the window, bit 7 the warning enable, bits [10:8] the prescaler and bit 16 the freeze bit. Each byte lane is written only when its strobe is set.
  - Index 2 is status: bit 0 is the flag.
  - Index 3 and all undefined bits read as zero.
- R11: A counter reload made while the warning is pending, with the counter at or below the window, prevents the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low block reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Read data for the indexed register (combinational) |
| dbg_halt | input | 1 | Debug halt indication |
| irq | output | 1 | Early warning interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A write or counter advance takes effect at the rising edge that samples it. The resulting rst_req pulse, flag change and irq change are all visible in the very next cycle. Read data follows the word index in the same cycle, because it is combinational from the register state.

The bench keeps a behavioural model that is updated on the same rising edge. It compares rst_req, irq and read data at every falling edge, so each result is checked exactly one edge after its cause. Directed checks poll with bounded loops and also sample at falling edges, never at the active edge.

// File: rtl/wwd_pkg.sv
`timescale 1ns/1ps
package wwd_pkg;
  localparam int CNT_W   = 7;
  localparam int PSC_W   = 3;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;
  localparam int PSC_MAX = (1 << PSC_W) - 1;

  localparam logic [CNT_W-1:0] CNT_RESET  = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_RESET  = 7'h7F;
  localparam logic [CNT_W-1:0] EXPIRE_VAL = 7'h40;
  localparam logic [CNT_W-1:0] WARN_PREV  = 7'h41;

  localparam int CONF_EN_BIT  = 7;
  localparam int CONF_PSC_LSB = 8;
  localparam int CONF_FRZ_BIT = 16;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CONF = 2'd1,
    IDX_STAT = 2'd2,
    IDX_NONE = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic             halt_freeze;
    logic [PSC_W-1:0] psc;
    logic             warn_en;
    logic [CNT_W-1:0] window;
  } conf_t;

  // merge new bytes into an old word lane by lane
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    for (int b = 0; b < STRB_W; b++) begin
      res[b*8 +: 8] = strb[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] conf_to_word(input conf_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = c.window;
    w[CONF_EN_BIT] = c.warn_en;
    w[CONF_PSC_LSB +: PSC_W] = c.psc;
    w[CONF_FRZ_BIT] = c.halt_freeze;
    return w;
  endfunction

  function automatic conf_t word_to_conf(input logic [DATA_W-1:0] w);
    conf_t c;
    c.window      = w[CNT_W-1:0];
    c.warn_en     = w[CONF_EN_BIT];
    c.psc         = w[CONF_PSC_LSB +: PSC_W];
    c.halt_freeze = w[CONF_FRZ_BIT];
    return c;
  endfunction

  // bus cycles per counter advance
  function automatic longint unsigned tick_cycles(input int div_log2, input int psc);
    return 64'd1 << (div_log2 + psc);
  endfunction

  // bus cycles from a reload with low six bits t_low until expiry
  function automatic longint unsigned timeout_cycles(input int div_log2, input int psc,
                                                     input int t_low);
    return tick_cycles(div_log2, psc) * longint'(t_low + 1);
  endfunction
endpackage

// File: rtl/wwd_tick.sv
`timescale 1ns/1ps
module wwd_tick
  import wwd_pkg::*;
#(
  parameter int DIV_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int PC_W = DIV_LOG2 + PSC_MAX;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] mask;

  // low DIV_LOG2+psc bits select the advance period
  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < DIV_LOG2 + int'(psc));
    end
  end

  assign tick = run && ((pc & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (run) begin
      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/wwd_core.sv
`timescale 1ns/1ps
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_data,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             warn_evt,
  output logic             ev_expire,
  output logic             ev_badwr,
  output logic             rst_req
);
  logic wr_active;
  logic advance;

  assign wr_active = active | ctrl_data[CNT_W];
  assign advance   = tick && !ctrl_wr;
  assign ev_badwr  = ctrl_wr && wr_active &&
                     (!ctrl_data[CNT_W-1] || (cnt > window));
  assign ev_expire = advance && active && (cnt == EXPIRE_VAL);
  assign warn_evt  = advance && (cnt == WARN_PREV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_RESET;
      active  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= ev_badwr | ev_expire;
      if (ctrl_wr) begin
        cnt <= ctrl_data[CNT_W-1:0];
        if (ctrl_data[CNT_W]) active <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wwd_regs.sv
`timescale 1ns/1ps
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_strb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              active,
  input  logic              flag_set,
  output conf_t             conf,
  output logic              flag,
  output logic              ctrl_wr,
  output logic [7:0]        ctrl_data,
  output logic              flag_clr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr_hit;
  logic hit_ctrl, hit_conf, hit_stat;

  assign wr_hit   = bus_sel && bus_wr;
  assign hit_ctrl = (bus_addr == ADDR_W'(IDX_CTRL));
  assign hit_conf = (bus_addr == ADDR_W'(IDX_CONF));
  assign hit_stat = (bus_addr == ADDR_W'(IDX_STAT));

  assign ctrl_wr   = wr_hit && hit_ctrl && bus_strb[0];
  assign ctrl_data = bus_wdata[7:0];
  assign flag_clr  = wr_hit && hit_stat && bus_strb[0] && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf <= word_to_conf(DATA_W'(WIN_RESET));
      flag <= 1'b0;
    end else begin
      if (wr_hit && hit_conf) begin
        conf <= word_to_conf(lane_merge(conf_to_word(conf), bus_wdata, bus_strb));
      end
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CNT_W-1:0] = cnt;
      bus_rdata[CNT_W]     = active;
    end else if (hit_conf) begin
      bus_rdata = conf_to_word(conf);
    end else if (hit_stat) begin
      bus_rdata[0] = flag;
    end
  end
endmodule

// File: rtl/window_watchdog.sv
`timescale 1ns/1ps
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int DIV_LOG2 = 12,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_strb,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              rst_req
);
  conf_t            conf;
  logic             flag, flag_clr, warn_evt;
  logic             ctrl_wr;
  logic [7:0]       ctrl_data;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             tick, frozen;
  logic             ev_expire, ev_badwr;

  assign frozen = dbg_halt && conf.halt_freeze;
  assign irq    = flag && conf.warn_en;

  wwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .cnt       (cnt),
    .active    (active),
    .flag_set  (warn_evt),
    .conf      (conf),
    .flag      (flag),
    .ctrl_wr   (ctrl_wr),
    .ctrl_data (ctrl_data),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  wwd_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!frozen),
    .psc   (conf.psc),
    .tick  (tick)
  );

  wwd_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctrl_wr   (ctrl_wr),
    .ctrl_data (ctrl_data),
    .window    (conf.window),
    .cnt       (cnt),
    .active    (active),
    .warn_evt  (warn_evt),
    .ev_expire (ev_expire),
    .ev_badwr  (ev_badwr),
    .rst_req   (rst_req)
  );
endmodule

// File: rtl/wwd_checker.sv
`timescale 1ns/1ps
module wwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic [6:0] cnt,
  input logic [6:0] window,
  input logic       flag,
  input logic       flag_clr,
  input logic       rst_req,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_data,
  input logic       frozen
);
  AST_WINDOW_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (active || ctrl_data[7]) && (cnt > window)) |=> rst_req); // R8
  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (active || ctrl_data[7]) && !ctrl_data[6]) |=> rst_req); // R7
  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ctrl_wr && cnt == 7'h40) ##1 (cnt == 7'h3F) |-> rst_req); // R6
  AST_QUIET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(ctrl_wr && ctrl_data[7])) |=> !rst_req); // R6
  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R5
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == 7'h40 && $past(cnt) == 7'h41)); // R4
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ctrl_wr) |=> $stable(cnt)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) - 7'd1)); // R3
endmodule

bind window_watchdog wwd_checker u_wwd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .cnt       (cnt),
  .window    (conf.window),
  .flag      (flag),
  .flag_clr  (flag_clr),
  .rst_req   (rst_req),
  .ctrl_wr   (ctrl_wr),
  .ctrl_data (ctrl_data),
  .frozen    (frozen)
);

// File: tb/window_watchdog_test.sv
`timescale 1ns/1ps
module window_watchdog_test;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_sel = 1'b0, b_wr = 1'b0;
  logic [1:0]  b_addr = 2'd0;
  logic [31:0] b_wdata = '0;
  logic [3:0]  b_strb = '0;
  logic        dbg_halt = 1'b0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  bit saw_rst;

  window_watchdog #(.DIV_LOG2(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_strb(b_strb), .bus_rdata(rdata),
    .dbg_halt(dbg_halt), .irq(irq), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference model
  int m_cnt, m_pc, m_win, m_psc;
  bit m_act, m_en, m_frz, m_flag, m_rst;
  bit mr_run, mr_tick, mr_cw, mr_fclr, mr_fset;
  int mr_period;
  logic [7:0] mr_d;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
    if (!rst_n) begin
      m_cnt = 127; m_act = 0; m_win = 127; m_en = 0; m_psc = 0; m_frz = 0;
      m_flag = 0; m_pc = 0; m_rst = 0;
    end else begin
      mr_run    = !(dbg_halt && m_frz);
      mr_period = 1 << (DIV + m_psc);
      mr_tick   = mr_run && ((m_pc % mr_period) == mr_period - 1);
      mr_cw     = b_sel && b_wr && b_addr == 2'd0 && b_strb[0];
      mr_d      = b_wdata[7:0];
      mr_fclr   = b_sel && b_wr && b_addr == 2'd2 && b_strb[0] && !b_wdata[0];
      mr_fset   = mr_tick && !mr_cw && m_cnt == 65;
      m_rst = 0;
      if (mr_cw) begin
        if ((m_act || mr_d[7]) && (!mr_d[6] || m_cnt > m_win)) m_rst = 1;
        m_cnt = int'(mr_d[6:0]);
        if (mr_d[7]) m_act = 1;
      end else if (mr_tick) begin
        if (m_cnt == 64 && m_act) m_rst = 1;
        m_cnt = (m_cnt + 127) % 128;
      end
      if (mr_fset) m_flag = 1;
      else if (mr_fclr) m_flag = 0;
      if (b_sel && b_wr && b_addr == 2'd1) begin
        if (b_strb[0]) begin m_win = int'(b_wdata[6:0]); m_en = b_wdata[7]; end
        if (b_strb[1]) m_psc = int'(b_wdata[10:8]);
        if (b_strb[2]) m_frz = b_wdata[16];
      end
      if (mr_run) m_pc = (m_pc + 1) % (1 << (DIV + 7));
    end
  end

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return {24'd0, m_act, 7'(m_cnt)};
      2'd1: return {15'd0, m_frz, 5'd0, 3'(m_psc), m_en, 7'(m_win)};
      2'd2: return {31'd0, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 rst_req vs model", rst_req, m_rst);
      check("R4 irq vs model", irq, m_flag && m_en);
      check("R10 read data vs model", rdata, model_rd(b_addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); #1;
    b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d; b_strb = s;
    @(negedge clk);
    saw_rst = rst_req;
    #1; b_sel = 0; b_wr = 0; b_strb = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); #1; b_addr = a;
    @(negedge clk); v = rdata;
  endtask

  initial begin : stim
    logic [31:0] v, v2;
    int pulses, t0, t1;
    bit hit;
    longint unsigned tc;

    idle(3); #1; rst_n = 1;
    // R2 reset state
    rd(2'd0, v); check("R2 control reset", v, 32'h7F);
    rd(2'd1, v); check("R2 config reset", v, 32'h7F);
    rd(2'd2, v); check("R2 status reset", v, 32'h0);
    check("R2 irq reset", irq, 0);
    check("R2 rst_req reset", rst_req, 0);

    // R3/R4/R6 inactive run down to 0x40
    @(negedge clk); #1; b_addr = 2'd0;
    hit = 0;
    for (int i = 0; i < 600 && !hit; i++) begin
      @(negedge clk);
      if (rdata[6:0] == 7'h40) hit = 1;
    end
    check("R3 counter reached 0x40", hit, 1);
    rd(2'd2, v); check("R4 flag set at 0x40", v, 32'h1);
    check("R4 irq gated by enable", irq, 0);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (rst_req) pulses++; end
    check("R6 no reset while inactive", pulses, 0);

    // R5 flag clearing
    wr(2'd2, 32'h1, 4'hF); rd(2'd2, v); check("R5 writing 1 keeps flag", v, 32'h1);
    wr(2'd2, 32'h0, 4'hF); rd(2'd2, v); check("R5 writing 0 clears flag", v, 32'h0);

    // R10 byte lanes of config
    wr(2'd1, 32'h0000_00D0, 4'hF); rd(2'd1, v); check("R10 config full write", v, 32'hD0);
    wr(2'd1, 32'h0001_0000, 4'hC); rd(2'd1, v); check("R10 upper half write", v, 32'h100D0);
    wr(2'd1, 32'h0000_02FF, 4'h3); rd(2'd1, v); check("R10 lower half write", v, 32'h102FF);
    wr(2'd1, 32'h0000_0000, 4'hC); rd(2'd1, v); check("R10 upper half clear", v, 32'h002FF);
    wr(2'd1, 32'h0000_00FF, 4'h3); rd(2'd1, v); check("R1 prescaler back to 0", v, 32'h000FF);

    // R6 activate and expire
    wr(2'd0, 32'hC5, 4'hF); check("R7 activating write no reset", saw_rst, 0);
    @(negedge clk); #1; b_addr = 2'd0;
    hit = 0;
    for (int i = 0; i < 100 && !hit; i++) begin @(negedge clk); if (irq) hit = 1; end
    check("R4 irq raised", hit, 1);
    check("R4 counter at warning", rdata, 32'hC0);
    hit = 0;
    for (int i = 0; i < 20 && !hit; i++) begin @(negedge clk); if (rst_req) hit = 1; end
    check("R6 expiry pulse seen", hit, 1);
    check("R6 counter after expiry", rdata, 32'hBF);
    @(negedge clk); check("R6 pulse one cycle", rst_req, 0);

    // R11 recovery from a pending warning
    wr(2'd1, 32'h0000_00D0, 4'h1);
    wr(2'd0, 32'hC8, 4'hF); check("R8 reload below window", saw_rst, 0);
    wr(2'd2, 32'h0, 4'hF);
    hit = 0;
    for (int i = 0; i < 100 && !hit; i++) begin @(negedge clk); if (irq) hit = 1; end
    check("R4 warning again", hit, 1);
    wr(2'd0, 32'hCA, 4'hF); check("R11 reload under warning", saw_rst, 0);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (rst_req) pulses++; end
    check("R11 no reset after reload", pulses, 0);

    // R8 early refresh
    wr(2'd0, 32'hFF, 4'hF); check("R8 refresh inside window", saw_rst, 0);
    wr(2'd0, 32'hFF, 4'hF); check("R8 refresh above window", saw_rst, 1);

    // R7 bit 6 low write
    wr(2'd1, 32'h0000_00FF, 4'h1);
    wr(2'd0, 32'h85, 4'hF); check("R7 bit6 low write", saw_rst, 1);
    wr(2'd0, 32'hFF, 4'hF); check("R8 counter under window", saw_rst, 0);

    // R9 sticky activation
    wr(2'd0, 32'h7F, 4'hF); rd(2'd0, v); check("R9 activation sticky", v[7], 1);

    // R3 freeze under debug halt
    wr(2'd1, 32'h0001_0000, 4'h4);
    @(negedge clk); #1; dbg_halt = 1;
    idle(2); rd(2'd0, v); idle(40); rd(2'd0, v2);
    check("R3 frozen counter holds", v2, v);
    @(negedge clk); #1; dbg_halt = 0;
    idle(40); rd(2'd0, v); check("R3 counter resumes", v != v2, 1);
    wr(2'd1, 32'h0, 4'h4);
    @(negedge clk); #1; dbg_halt = 1;
    rd(2'd0, v); idle(40); rd(2'd0, v2);
    check("R3 halt ignored without freeze bit", v2 != v, 1);
    @(negedge clk); #1; dbg_halt = 0;
    wr(2'd0, 32'hFF, 4'hF);

    // R1 advance period with prescaler 2
    wr(2'd1, 32'h0000_0200, 4'h2);
    @(negedge clk); #1; b_addr = 2'd0;
    @(negedge clk); v = rdata;
    t0 = 0; t1 = 0;
    for (int k = 0; k < 3; k++) begin
      hit = 0;
      for (int i = 0; i < 40 && !hit; i++) begin
        @(negedge clk);
        if (rdata != v) begin hit = 1; v = rdata; end
      end
      if (k == 1) t0 = cyc;
      if (k == 2) t1 = cyc;
    end
    check("R1 advance period psc=2", t1 - t0, 16);

    // R1 timeout arithmetic
    tc = wwd_pkg::timeout_cycles(12, 3, 63);
    check("R1 timeout cycles", tc, 64'd2097152);
    check("R1 timeout 48MHz in 10us units", (tc * 100000) / 48000000, 64'd4369);

    idle(5);
    finish_run();
  end
endmodule